// File: doc/BRIEF.md
# A-law to mu-law code translator

This block rewrites one 8-bit companded sample from the A-law code to the mu-law code. Each code byte carries a polarity bit in the MSB, then a 3-bit segment, then a 4-bit step value in the low nibble. Input and output use the same layout. A single 4-bit adder adds a constant, chosen by the segment, to the step value. The carry out of that adder decides two things at once: whether the segment stays the same or drops by one, and whether the sum is halved. Segments 0 and 1 bypass the adder path.

The host places a code on `code_i` and pulses `strobe_i`. The translated code is registered and appears on `code_o` on the next clock edge, together with a one-cycle `valid_o` pulse. Between strobes, `code_o` holds its last value.

Top module: `a2u_translator`

## Requirements
- R1: The polarity bit (bit 7) of the output equals the polarity bit of the input.
- R2: When the input segment (bits 6:4) is 0, the output segment and value (bits 3:0) equal the input segment and value.
- R3: When the input segment is 1, the output segment is 1 and the output value is the input value shifted right by one bit, with a 0 entering at the top.
- R4: For segments 2, 3, 4 and 5, the constant added to the value is 8, 4, 2 and 1 respectively. For segments 6 and 7 the constant is 0. With value 0, segments 2 to 5 give an output value equal to that constant and an output segment one below the input.
- R5: For segments 2 to 7, if value + constant overflows 4 bits, the output segment equals the input segment. The output value is then the 5-bit sum shifted right by one, with the carry as the new bit 3.
- R6: For segments 2 to 7, if value + constant does not overflow, the output segment is the input segment minus one and the output value is the 4-bit sum.
- R7: For segments 6 and 7, the output value equals the input value and the output segment is one lower.
- R8: `valid_o` is high for exactly the cycle after each clock edge that samples `strobe_i` high, and `code_o` carries that input's translation in that cycle. When `strobe_i` is low at an edge, `valid_o` is low afterwards and `code_o` does not change.
- R9: While `rst_ni` is low, `valid_o` is 0 and `code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample `code_i` on this edge |
| code_i | input | 8 | A-law code: polarity, segment[2:0], value[3:0] |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| code_o | output | 8 | mu-law code, same layout as the input |

## Verification
A wrong segment constant or a wrong carry steer shows up on `code_o` in the cycle right after the strobe. Because every one of the 256 input codes is swept, any fault in the decoder or the mux appears as at least one mismatched code. A stuck or extra `valid_o` pulse, or a `code_o` that changes while idle, shows up one edge after any idle cycle. The idle gaps placed between strobes expose these faults within one cycle.

// File: rtl/a2u_pkg.sv
package a2u_pkg;
  localparam int unsigned SEG_W  = 3;
  localparam int unsigned VAL_W  = 4;
  localparam int unsigned CODE_W = 1 + SEG_W + VAL_W;

  typedef struct packed {
    logic             pol;
    logic [SEG_W-1:0] seg;
    logic [VAL_W-1:0] val;
  } code_t;
endpackage

// File: rtl/a2u_seg_const.sv
module a2u_seg_const #(
  parameter int unsigned SEG_W = 3,
  parameter int unsigned VAL_W = 4
) (
  input  logic [SEG_W-1:0] seg_i,
  output logic [VAL_W-1:0] z_o
);
  localparam int unsigned NSEG = 2 ** SEG_W;

  logic [VAL_W-1:0] term [NSEG];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    // constant halves per segment from 2 upward, zero once the shift runs out
    localparam int SH = VAL_W + 1 - k;
    localparam logic [VAL_W-1:0] ZK =
      (k >= 2 && k <= VAL_W + 1) ? VAL_W'(1 << SH) : '0;
    assign term[k] = (seg_i == SEG_W'(k)) ? ZK : '0;
  end

  always_comb begin
    z_o = '0;
    for (int k = 0; k < NSEG; k++) z_o = z_o | term[k];
  end
endmodule

// File: rtl/a2u_shared_adder.sv
module a2u_shared_adder #(
  parameter int unsigned VAL_W = 4
) (
  input  logic [VAL_W-1:0] a_i,
  input  logic [VAL_W-1:0] b_i,
  output logic [VAL_W-1:0] sum_o,
  output logic             co_o
);
  assign {co_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/a2u_out_select.sv
module a2u_out_select #(
  parameter int unsigned SEG_W = 3,
  parameter int unsigned VAL_W = 4
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic [VAL_W-1:0] sum_i,
  input  logic             co_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [VAL_W-1:0] val_o
);
  logic [SEG_W-1:0] seg_dn;

  // decrement as an add of all-ones, wraps mod 2^SEG_W
  assign seg_dn = seg_i + {SEG_W{1'b1}};

  always_comb begin
    if (seg_i == '0) begin
      seg_o = seg_i;
      val_o = val_i;
    end else if (seg_i == SEG_W'(1)) begin
      seg_o = seg_i;
      val_o = {1'b0, val_i[VAL_W-1:1]};
    end else if (co_i) begin
      seg_o = seg_i;
      val_o = {co_i, sum_i[VAL_W-1:1]};
    end else begin
      seg_o = seg_dn;
      val_o = sum_i;
    end
  end
endmodule

// File: rtl/a2u_translator.sv
module a2u_translator
  import a2u_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  code_t            in_c, res_c;
  logic [VAL_W-1:0] z, sum;
  logic             co;

  assign in_c = code_t'(code_i);

  a2u_seg_const #(.SEG_W(SEG_W), .VAL_W(VAL_W)) u_const (
    .seg_i (in_c.seg),
    .z_o   (z)
  );

  a2u_shared_adder #(.VAL_W(VAL_W)) u_add (
    .a_i   (in_c.val),
    .b_i   (z),
    .sum_o (sum),
    .co_o  (co)
  );

  a2u_out_select #(.SEG_W(SEG_W), .VAL_W(VAL_W)) u_sel (
    .seg_i (in_c.seg),
    .val_i (in_c.val),
    .sum_i (sum),
    .co_i  (co),
    .seg_o (res_c.seg),
    .val_o (res_c.val)
  );

  assign res_c.pol = in_c.pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) code_o <= res_c;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> (!valid_o && $stable(code_o)));  // R8
  AST_POL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> code_o[CODE_W-1] == $past(code_i[CODE_W-1]));  // R1
  AST_SEG0_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_c.seg == '0) |=> code_o == $past(code_i));  // R2
  AST_SEG1_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_c.seg == SEG_W'(1)) |=>
      (code_o[CODE_W-2 -: SEG_W] == SEG_W'(1) && !code_o[VAL_W-1]));  // R3
  AST_Z_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(z));  // R4
  AST_CARRY_KEEPS_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_c.seg >= SEG_W'(2) && co) |=>
      (code_o[CODE_W-2 -: SEG_W] == $past(code_i[CODE_W-2 -: SEG_W]) && code_o[VAL_W-1]));  // R5
  AST_NOCARRY_DROPS_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_c.seg >= SEG_W'(2) && !co) |=>
      code_o[CODE_W-2 -: SEG_W] == $past(code_i[CODE_W-2 -: SEG_W]) - SEG_W'(1));  // R6
  AST_TOP_SEG_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_c.seg >= SEG_W'(6)) |=> code_o[VAL_W-1:0] == $past(code_i[VAL_W-1:0]));  // R7
endmodule

// File: tb/a2u_translator_tb.sv
module a2u_translator_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic [7:0] code_i = '0;
  logic       valid_o;
  logic [7:0] code_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  a2u_translator u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .code_i(code_i), .valid_o(valid_o), .code_o(code_o)
  );

  function automatic logic [7:0] model(input logic [7:0] c);
    logic [2:0] s;
    logic [3:0] d, z;
    logic [4:0] t;
    s = c[6:4];
    d = c[3:0];
    case (s)
      3'd2: z = 4'd8;
      3'd3: z = 4'd4;
      3'd4: z = 4'd2;
      3'd5: z = 4'd1;
      default: z = 4'd0;
    endcase
    t = {1'b0, d} + {1'b0, z};
    if (s == 3'd0) return c;
    if (s == 3'd1) return {c[7], s, 1'b0, d[3:1]};
    if (t[4]) return {c[7], s, t[4:1]};
    return {c[7], s - 3'd1, t[3:0]};
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    logic [4:0] t;
    if (c[6:4] == 3'd0) return "R2";
    if (c[6:4] == 3'd1) return "R3";
    if (c[6:4] >= 3'd6) return "R7";
    t = {1'b0, c[3:0]} + {1'b0, (4'd1 << (3'd5 - c[6:4]))};
    return t[4] ? "R5" : "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    logic [7:0] e;
    e = model(c);
    @(negedge clk_i);
    code_i = c;
    strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
    chk(valid_o == 1'b1, "R8", {7'd0, valid_o}, 8'd1);
    chk(code_o[7] == c[7], "R1", code_o, e);
    chk(code_o == e, tag_of(c), code_o, e);
  endtask

  task automatic idle_check();
    logic [7:0] held;
    held = code_o;
    code_i = ~code_i;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R8", {7'd0, valid_o}, 8'd0);
    chk(code_o == held, "R8", code_o, held);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R9", {7'd0, valid_o}, 8'd0);
    chk(code_o == 8'd0, "R9", code_o, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4: zero value exposes the constant per segment
    send(8'h20); chk(code_o[3:0] == 4'd8, "R4", code_o, 8'h18);
    send(8'h30); chk(code_o[3:0] == 4'd4, "R4", code_o, 8'h24);
    send(8'h40); chk(code_o[3:0] == 4'd2, "R4", code_o, 8'h32);
    send(8'h50); chk(code_o[3:0] == 4'd1, "R4", code_o, 8'h41);
    send(8'hEF);
    send(8'h7F);
    send(8'h5F);
    idle_check();

    // full sweep with idle gaps
    for (int i = 0; i < 256; i++) begin
      send(8'(i));
      if ((i % 17) == 0) idle_check();
    end

    // random order, random gaps
    for (int i = 0; i < 300; i++) begin
      send(8'($urandom));
      if ($urandom % 4 == 0) idle_check();
    end

    // R9: reset in mid-run clears outputs
    send(8'hA5);
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R9", {7'd0, valid_o}, 8'd0);
    chk(code_o == 8'd0, "R9", code_o, 8'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(8'h80);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule